// File: doc/BRIEF.md
# Embedded Operation Status Generator

This block forms the 8-bit word a host sees when it reads a flash bank that is busy with an internal program or erase. It gets the bank's operation mode, the map of sectors held in erase suspend, and the read strobe with its sector address and a bank-hit qualifier. From these it builds a status word with five signals:

- a polling bit that shows the complement of the bit being written;
- two toggle bits that flip on successive reads;
- a sticky failure flag;
- a flag that tells whether the erase window has closed.

When no operation is active, or when the read targets a sector that is not suspended, the word is the array data given on `array_q`.

The status word is registered. It is updated only on the clock edge that sees a rising edge of the read strobe. A failure is latched together with the mode it happened in. It stays visible until a reset command arrives, even if the mode input moves on in the meantime.

Top module: `eos_status_gen`

## Requirements
- R1: After reset, `status_q` is 0 and both toggle bits start at 0, so the first toggling read returns 1 in that bit.
- R2: In program mode (`op_mode`=1), a read returns bit 7 = inverse of `prog_d[7]`, bit 6 toggled, bit 5 = failure flag, bit 2 held, and bits 4, 3, 1, 0 = 0.
- R3: In the erase window (`op_mode`=2) and in erasing (`op_mode`=3), a read returns bit 7 = 0 and toggles both bit 6 and bit 2. Bit 3 reads 0 in the window and 1 while erasing.
- R4: In suspend-read (`op_mode`=4), a read of a sector whose `susp_map` bit is set returns bit 7 = 1 with bit 6 held and bit 2 toggled. A read of any other sector returns `array_q`.
- R5: In idle (`op_mode`=0), a read returns `array_q` and advances neither toggle bit.
- R6: A read with `bank_hit` low returns `array_q` and advances neither toggle bit.
- R7: `status_q` changes only on a rising edge of `rd_stb`. A strobe held high counts as one read.
- R8: A `limit_hit` pulse during modes 1, 2, 3 or 5 sets bit 5. The status then keeps the form of the mode that failed, with bit 6 still toggling, until `reset_cmd` arrives, even if `op_mode` changes.
- R9: In program mode, a `prog_d` bit at 1 over an `array_q` bit at 0 sets the failure flag the same way as R8.
- R10: `reset_cmd` clears the failure flag. The next read follows the current `op_mode`.
- R11: In suspend-program (`op_mode`=5), reads return the program status of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_mode | input | 3 | 0 idle, 1 program, 2 erase window, 3 erasing, 4 suspend-read, 5 suspend-program |
| limit_hit | input | 1 | Operation exceeded its time limit (pulse) |
| reset_cmd | input | 1 | Reset command, clears the failure flag |
| susp_map | input | NSECT | One bit per sector held in erase suspend |
| rd_stb | input | 1 | Read strobe, acts on its rising edge |
| bank_hit | input | 1 | Read addresses this bank |
| rd_sect | input | SECT_W | Sector index of the read |
| prog_d | input | 8 | Data being programmed |
| array_q | input | 8 | Array contents at the read or target address |
| status_q | output | 8 | Registered read word |

## Verification
A toggle bit that advances at the wrong moment shows up as bit 6 or bit 2 carrying the wrong phase on the very next read, and it stays off by one for every read after that. Reads in idle, on other banks and during held strobes are placed between toggling reads to expose exactly this. A failure latch that drops early or records the wrong mode changes bit 5 or bit 7 on the first read after the mode input moves. That read is made before the reset command is sent.

// File: rtl/eos_pkg.sv
package eos_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    M_IDLE    = 3'd0,
    M_PROG    = 3'd1,
    M_EWIN    = 3'd2,
    M_ERASE   = 3'd3,
    M_SUSP_RD = 3'd4,
    M_SUSP_PG = 3'd5
  } op_mode_e;

  function automatic logic mode_busy(input op_mode_e m);
    return (m == M_PROG) || (m == M_EWIN) || (m == M_ERASE) || (m == M_SUSP_PG);
  endfunction

  function automatic logic mode_erasing(input op_mode_e m);
    return (m == M_EWIN) || (m == M_ERASE);
  endfunction
endpackage

// File: rtl/eos_rst_sync.sv
module eos_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [1:0] sh_q;
  logic [1:0] sh_d;

  always_comb sh_d = {sh_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= sh_d;
  end

  assign rst_s = sh_q[1];
endmodule

// File: rtl/eos_fail_latch.sv
module eos_fail_latch
  import eos_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  op_mode_e mode,
  input  logic     limit_hit,
  input  logic     reset_cmd,
  input  logic     bad_prog,
  output logic     err_q,
  output op_mode_e err_mode_q
);
  logic     err_d;
  op_mode_e mode_d;
  logic     set_err;

  always_comb begin
    set_err = !err_q && ((limit_hit && mode_busy(mode)) || (bad_prog && mode == M_PROG));
    err_d   = err_q;
    mode_d  = err_mode_q;
    if (reset_cmd) begin
      err_d = 1'b0;
    end else if (set_err) begin
      err_d  = 1'b1;
      mode_d = mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q      <= 1'b0;
      err_mode_q <= M_IDLE;
    end else begin
      err_q      <= err_d;
      err_mode_q <= mode_d;
    end
  end
endmodule

// File: rtl/eos_toggle_pair.sv
module eos_toggle_pair (
  input  logic clk,
  input  logic rst_n,
  input  logic adv_en,
  input  logic adv6,
  input  logic adv2,
  output logic t6_nxt,
  output logic t2_nxt
);
  logic t6_q;
  logic t2_q;

  always_comb begin
    t6_nxt = t6_q ^ (adv_en & adv6);
    t2_nxt = t2_q ^ (adv_en & adv2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t6_q <= 1'b0;
      t2_q <= 1'b0;
    end else if (adv_en) begin
      t6_q <= t6_nxt;
      t2_q <= t2_nxt;
    end
  end
endmodule

// File: rtl/eos_status_gen.sv
module eos_status_gen
  import eos_pkg::*;
#(
  parameter int unsigned NSECT  = 16,
  parameter int unsigned SECT_W = (NSECT > 1) ? $clog2(NSECT) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           op_mode,
  input  logic                 limit_hit,
  input  logic                 reset_cmd,
  input  logic [NSECT-1:0]     susp_map,
  input  logic                 rd_stb,
  input  logic                 bank_hit,
  input  logic [SECT_W-1:0]    rd_sect,
  input  logic [BYTE_W-1:0]    prog_d,
  input  logic [BYTE_W-1:0]    array_q,
  output logic [BYTE_W-1:0]    status_q
);
  logic        rst_s;
  op_mode_e    mode_in;
  op_mode_e    err_mode;
  op_mode_e    eff_mode;
  logic        err_q;
  logic        rd_q;
  logic        rd_rise;
  logic        hit_rd;
  logic        sect_susp;
  logic        adv6;
  logic        adv2;
  logic        t6_nxt;
  logic        t2_nxt;
  logic        bad_prog;
  logic [BYTE_W-1:0] word_d;
  logic [BYTE_W-1:0] status_d;

  eos_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_s(rst_s));

  assign mode_in  = op_mode_e'(op_mode);
  assign bad_prog = |(prog_d & ~array_q);

  eos_fail_latch u_err (
    .clk(clk), .rst_n(rst_s), .mode(mode_in), .limit_hit(limit_hit),
    .reset_cmd(reset_cmd), .bad_prog(bad_prog), .err_q(err_q), .err_mode_q(err_mode)
  );

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) rd_q <= 1'b0;
    else        rd_q <= rd_stb;
  end

  always_comb begin
    rd_rise   = rd_stb & ~rd_q;
    hit_rd    = rd_rise & bank_hit;
    eff_mode  = err_q ? err_mode : mode_in;
    sect_susp = susp_map[rd_sect];
    adv6      = mode_busy(eff_mode);
    adv2      = mode_erasing(eff_mode) || (eff_mode == M_SUSP_RD && sect_susp);
  end

  eos_toggle_pair u_tog (
    .clk(clk), .rst_n(rst_s), .adv_en(hit_rd), .adv6(adv6), .adv2(adv2),
    .t6_nxt(t6_nxt), .t2_nxt(t2_nxt)
  );

  always_comb begin
    case (eff_mode)
      M_PROG, M_SUSP_PG: word_d = {~prog_d[7], t6_nxt, err_q, 2'b00, t2_nxt, 2'b00};
      M_EWIN:            word_d = {1'b0, t6_nxt, err_q, 2'b00, t2_nxt, 2'b00};
      M_ERASE:           word_d = {1'b0, t6_nxt, err_q, 2'b01, t2_nxt, 2'b00};
      M_SUSP_RD:         word_d = sect_susp ? {1'b1, t6_nxt, 3'b000, t2_nxt, 2'b00} : array_q;
      default:           word_d = array_q;
    endcase
    status_d = status_q;
    if (rd_rise) status_d = bank_hit ? word_d : array_q;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) status_q <= '0;
    else        status_q <= status_d;
  end
endmodule

// File: rtl/eos_status_chk.sv
module eos_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] op_mode,
  input logic       rd_stb,
  input logic       bank_hit,
  input logic       reset_cmd,
  input logic [7:0] prog_d,
  input logic [7:0] array_q,
  input logic       err_q,
  input logic [7:0] status_q
);
  // R2
  prog_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !$past(rd_stb) && bank_hit && op_mode == 3'd1 && !err_q)
      |=> (status_q[7] == ~$past(prog_d[7]) && status_q[4:3] == 2'b00));

  // R3
  erase_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !$past(rd_stb) && bank_hit && op_mode == 3'd3 && !err_q)
      |=> (status_q[3] && !status_q[7]));

  // R6
  other_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !$past(rd_stb) && !bank_hit) |=> (status_q == $past(array_q)));

  // R7
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && !$past(rd_stb)) |=> $stable(status_q));

  // R8
  sticky_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !reset_cmd) |=> err_q);

  // R10
  clear_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_cmd |=> !err_q);
endmodule

bind eos_status_gen eos_status_chk u_chk (
  .clk(clk), .rst_n(rst_s), .op_mode(op_mode), .rd_stb(rd_stb), .bank_hit(bank_hit),
  .reset_cmd(reset_cmd), .prog_d(prog_d), .array_q(array_q), .err_q(err_q),
  .status_q(status_q)
);

// File: tb/tb_eos_status_gen.sv
module tb_eos_status_gen;
  localparam int NSECT = 16;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [2:0] op_mode;
  logic limit_hit, reset_cmd, rd_stb, bank_hit;
  logic [NSECT-1:0] susp_map;
  logic [SW-1:0] rd_sect;
  logic [7:0] prog_d, array_q, status_q;

  eos_status_gen #(.NSECT(NSECT)) dut (
    .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .limit_hit(limit_hit),
    .reset_cmd(reset_cmd), .susp_map(susp_map), .rd_stb(rd_stb), .bank_hit(bank_hit),
    .rd_sect(rd_sect), .prog_d(prog_d), .array_q(array_q), .status_q(status_q)
  );

  always #5 clk = ~clk;

  logic [7:0] exp_q[$];
  string      req_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit m_t6 = 0, m_t2 = 0, m_err = 0;
  logic [2:0] m_errmode = 3'd0;

  initial forever begin
    logic [7:0] e;
    string r;
    wait (exp_q.size() > 0);
    @(negedge clk);
    e = exp_q.pop_front();
    r = req_q.pop_front();
    checks++;
    if (status_q !== e) begin
      errors++;
      $display("FAIL %s: status got %h expected %h", r, status_q, e);
    end
  end

  function automatic logic [7:0] model_read(input logic [SW-1:0] s, input bit hit);
    logic [2:0] m;
    bit a6, a2;
    if (!hit) return array_q;
    m  = m_err ? m_errmode : op_mode;
    a6 = (m == 3'd1) || (m == 3'd2) || (m == 3'd3) || (m == 3'd5);
    a2 = (m == 3'd2) || (m == 3'd3) || (m == 3'd4 && susp_map[s]);
    m_t6 ^= a6;
    m_t2 ^= a2;
    case (m)
      3'd1, 3'd5: return {~prog_d[7], m_t6, m_err, 2'b00, m_t2, 2'b00};
      3'd2:       return {1'b0, m_t6, m_err, 2'b00, m_t2, 2'b00};
      3'd3:       return {1'b0, m_t6, m_err, 2'b01, m_t2, 2'b00};
      3'd4:       return susp_map[s] ? {1'b1, m_t6, 3'b000, m_t2, 2'b00} : array_q;
      default:    return array_q;
    endcase
  endfunction

  task automatic do_read(input logic [SW-1:0] s, input bit hit, input string r, input int hold);
    @(negedge clk);
    rd_sect = s;
    bank_hit = hit;
    rd_stb = 1'b1;
    exp_q.push_back(model_read(s, hit));
    req_q.push_back(r);
    repeat (hold) @(negedge clk);
    if (hold > 2) begin
      exp_q.push_back(exp_q.size() > 0 ? exp_q[$] : status_q);
      req_q.push_back("R7");
    end
    @(negedge clk);
    rd_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_limit();
    @(negedge clk);
    limit_hit = 1'b1;
    if (!m_err && (op_mode inside {3'd1, 3'd2, 3'd3, 3'd5})) begin
      m_err = 1;
      m_errmode = op_mode;
    end
    @(negedge clk);
    limit_hit = 1'b0;
  endtask

  task automatic pulse_reset_cmd();
    @(negedge clk);
    reset_cmd = 1'b1;
    m_err = 0;
    @(negedge clk);
    reset_cmd = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; op_mode = 3'd0; limit_hit = 0; reset_cmd = 0; rd_stb = 0;
    bank_hit = 1; rd_sect = '0; susp_map = '0; prog_d = 8'hA5; array_q = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    exp_q.push_back(8'h00); req_q.push_back("R1");
    @(negedge clk); @(negedge clk);

    op_mode = 3'd1;
    do_read(0, 1, "R1", 0);
    do_read(0, 1, "R2", 0);
    do_read(0, 1, "R2", 0);
    do_read(0, 1, "R7", 4);
    do_read(0, 1, "R7", 0);
    do_read(2, 0, "R6", 0);
    do_read(2, 1, "R6", 0);

    op_mode = 3'd0; array_q = 8'h3C;
    do_read(1, 1, "R5", 0);
    op_mode = 3'd1; array_q = 8'hFF;
    do_read(1, 1, "R5", 0);

    op_mode = 3'd2;
    do_read(4, 1, "R3", 0);
    do_read(4, 1, "R3", 0);
    op_mode = 3'd3;
    do_read(4, 1, "R3", 0);

    op_mode = 3'd4; susp_map = 16'h0008; array_q = 8'h5A;
    do_read(3, 1, "R4", 0);
    do_read(3, 1, "R4", 0);
    do_read(5, 1, "R4", 0);

    op_mode = 3'd5; prog_d = 8'h12; array_q = 8'hFF;
    do_read(3, 1, "R11", 0);
    do_read(3, 1, "R11", 0);

    pulse_limit();
    do_read(3, 1, "R8", 0);
    op_mode = 3'd0; array_q = 8'h77;
    do_read(3, 1, "R8", 0);
    pulse_reset_cmd();
    do_read(3, 1, "R10", 0);

    op_mode = 3'd1; prog_d = 8'h81; array_q = 8'h01;
    @(negedge clk);
    m_err = 1; m_errmode = 3'd1;
    @(negedge clk);
    prog_d = 8'h01;
    do_read(0, 1, "R9", 0);
    pulse_reset_cmd();
    do_read(0, 1, "R10", 0);

    wait (exp_q.size() == 0);
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule